// File: doc/BRIEF.md
# Codec Control-Register Access Bridge

This block sits on the host side of a serial audio/modem codec link and gives software a way to read and write the control registers of up to three codecs. Software uses three 32-bit words. A command word names the codec, the direction, a register address and, for writes, the data. A result word returns the address and data of the last completed read, with a completion flag. A status word holds one not-ready flag per codec and a per-frame flag. Frame slotting, bit clocking and power control are handled elsewhere. Toward the codecs the bridge uses a plain request/acknowledge handshake and gets read data back as a separate response strobe.

Software polls the busy flag in the command word until it clears. For a read it then polls the result word until the completion flag sets. A codec that stays silent for a fixed number of link frames is flagged not-ready, and the bridge frees itself. This lets the same access path find out which codec positions are empty.

Top module: `codec_reg_bridge`

## Requirements
- R1: After a synchronous reset, the command, result and status words all read zero and no link request is pending.
- R2: A command word carries the codec index in bits [1:0], read-when-set in bit 2, a 7-bit register address in bits [15:9] and write data in bits [31:16]. From the cycle after an accepted write to the command word, these fields appear on the link request ports.
- R3: Command bit 8 (busy) reads 1 from the cycle after a command is accepted. It reads 0 from the cycle after the codec acknowledges the request.
- R4: A command written while busy is set, or while a read is still waiting for its response, is discarded. The pending request and the command word do not change.
- R5: A command naming codec index 3, or an odd register address (bit 9 set), is rejected. No request is raised and the command word keeps its old value.
- R6: Accepting a read command clears result bit 8 (read complete) in the same cycle that busy sets.
- R7: A response whose codec and address match the pending read loads the result word with data in [31:16], address in [15:9], bit 8 set and bits [7:0] zero.
- R8: A response that does not match the pending read, or that arrives when no read is waiting, leaves the result word unchanged.
- R9: A write is complete on acknowledge. It never changes the result word.
- R10: If TIMEOUT_FRAMES frame ticks pass without an acknowledge (or, for a read, without a response), the request is dropped and busy clears. Status bit 10+codec sets and result bit 8 stays clear. One tick fewer keeps the transfer pending.
- R11: Each frame tick sets status bit 13.
- R12: Status bits are cleared by writing 1s to them through the clear port. A set event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word written by software |
| cmd_rdata | output | 32 | Command word read-back, busy in bit 8 |
| result_rdata | output | 32 | Read result word |
| stat_clr_wr | input | 1 | Strobe for clearing status bits |
| stat_clr_mask | input | 32 | Write-one-to-clear mask for the status word |
| stat_rdata | output | 32 | Status word: not-ready bits 12..10, frame bit 13 |
| frame_tick | input | 1 | One pulse per link frame |
| link_req | output | 1 | Request pending toward the codec side |
| link_codec | output | 2 | Target codec index |
| link_rd | output | 1 | Request is a read |
| link_addr | output | 7 | Register address field |
| link_wdata | output | 16 | Write data |
| link_ack | input | 1 | Codec side accepted the request |
| link_rsp_valid | input | 1 | Read response strobe |
| link_rsp_codec | input | 2 | Responding codec index |
| link_rsp_addr | input | 7 | Address echoed with the response |
| link_rsp_data | input | 16 | Returned register data |

## Verification
A stuck transaction state shows up as busy never clearing, or as link_req staying high after an acknowledge. This is visible at the ports one cycle after the acknowledge or the final frame tick. A wrong latched codec or address shows up in the cycle after acceptance, as link port fields that differ from the command. A later mismatch makes a correct response get ignored and leaves result bit 8 clear. A timeout counter that is off by one shows as busy releasing a frame early or late, and as the not-ready bit landing on the wrong tick. A wrong clear of the completion flag shows in the result word one cycle after a read is accepted.

// File: rtl/codec_bridge_pkg.sv
package codec_bridge_pkg;
  localparam int CB_IDX_W     = 2;
  localparam int CB_ADDR_W    = 7;
  localparam int CB_DATA_W    = 16;
  localparam int CB_RD_BIT    = 2;
  localparam int CB_BUSY_BIT  = 8;
  localparam int CB_ADDR_LSB  = 9;
  localparam int CB_DATA_LSB  = 16;
  localparam int CB_NRDY_LSB  = 10;
  localparam int CB_FRAME_BIT = 13;

  typedef enum logic [1:0] {XS_IDLE, XS_REQ, XS_WAIT} xfer_state_t;

  typedef struct packed {
    logic [CB_DATA_W-1:0] wdata;
    logic [CB_ADDR_W-1:0] addr;
    logic                 rd;
    logic [CB_IDX_W-1:0]  codec;
  } cb_cmd_t;
endpackage

// File: rtl/cb_txn_ctrl.sv
module cb_txn_ctrl
  import codec_bridge_pkg::*;
#(
  parameter int TIMEOUT_FRAMES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  cb_cmd_t              cmd,
  input  logic                 frame_tick,
  input  logic                 link_ack,
  input  logic                 rsp_valid,
  input  logic [CB_IDX_W-1:0]  rsp_codec,
  input  logic [CB_ADDR_W-1:0] rsp_addr,
  output logic                 idle,
  output logic                 rsp_hit,
  output logic                 timeout,
  output logic                 link_req,
  output logic [CB_IDX_W-1:0]  link_codec,
  output logic                 link_rd,
  output logic [CB_ADDR_W-1:0] link_addr,
  output logic [CB_DATA_W-1:0] link_wdata
);
  localparam int CNT_W = $clog2(TIMEOUT_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_FRAMES - 1);

  xfer_state_t      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;
  cb_cmd_t          cmd_q;
  logic             expire;

  assign expire  = frame_tick && (cnt_q == CNT_LAST);
  assign rsp_hit = (state_q == XS_WAIT) && rsp_valid &&
                   (rsp_codec == cmd_q.codec) && (rsp_addr == cmd_q.addr);
  assign timeout = expire && (((state_q == XS_REQ) && !link_ack) ||
                              ((state_q == XS_WAIT) && !rsp_hit));
  assign idle    = (state_q == XS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= XS_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
      cmd_q   <= '0;
    end else begin
      case (state_q)
        XS_IDLE: if (accept) begin
          state_q <= XS_REQ;
          req_q   <= 1'b1;
          cmd_q   <= cmd;
          cnt_q   <= '0;
        end
        XS_REQ: if (link_ack) begin
          req_q   <= 1'b0;
          cnt_q   <= '0;
          state_q <= cmd_q.rd ? XS_WAIT : XS_IDLE;
        end else if (expire) begin
          req_q   <= 1'b0;
          state_q <= XS_IDLE;
        end else if (frame_tick) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
        XS_WAIT: if (rsp_hit || expire) begin
          state_q <= XS_IDLE;
        end else if (frame_tick) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign link_req   = req_q;
  assign link_codec = cmd_q.codec;
  assign link_rd    = cmd_q.rd;
  assign link_addr  = cmd_q.addr;
  assign link_wdata = cmd_q.wdata;
endmodule

// File: rtl/cb_result_reg.sv
module cb_result_reg
  import codec_bridge_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_valid,
  input  logic                 load,
  input  logic [CB_ADDR_W-1:0] addr,
  input  logic [CB_DATA_W-1:0] data,
  output logic [31:0]          result
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (load) begin
      result <= '0;
      result[CB_DATA_LSB +: CB_DATA_W] <= data;
      result[CB_ADDR_LSB +: CB_ADDR_W] <= addr;
      result[CB_BUSY_BIT]              <= 1'b1;
    end else if (clr_valid) begin
      result[CB_BUSY_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/cb_status_reg.sv
module cb_status_reg
  import codec_bridge_pkg::*;
#(
  parameter int NUM_CODECS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                nrdy_set,
  input  logic [CB_IDX_W-1:0] nrdy_codec,
  input  logic                frame_tick,
  input  logic                clr_wr,
  input  logic [31:0]         clr_mask,
  output logic [31:0]         status
);
  logic [NUM_CODECS-1:0] nrdy_q;
  logic                  frame_q;

  for (genvar i = 0; i < NUM_CODECS; i++) begin : g_nrdy
    always_ff @(posedge clk) begin
      if (rst)
        nrdy_q[i] <= 1'b0;
      else if (nrdy_set && (nrdy_codec == CB_IDX_W'(i)))
        nrdy_q[i] <= 1'b1;
      else if (clr_wr && clr_mask[CB_NRDY_LSB + i])
        nrdy_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      frame_q <= 1'b0;
    else if (frame_tick)
      frame_q <= 1'b1;
    else if (clr_wr && clr_mask[CB_FRAME_BIT])
      frame_q <= 1'b0;
  end

  always_comb begin
    status = '0;
    status[CB_NRDY_LSB +: NUM_CODECS] = nrdy_q;
    status[CB_FRAME_BIT]              = frame_q;
  end
endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
  import codec_bridge_pkg::*;
#(
  parameter int NUM_CODECS     = 3,
  parameter int TIMEOUT_FRAMES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic [31:0] result_rdata,
  input  logic        stat_clr_wr,
  input  logic [31:0] stat_clr_mask,
  output logic [31:0] stat_rdata,
  input  logic        frame_tick,
  output logic        link_req,
  output logic [1:0]  link_codec,
  output logic        link_rd,
  output logic [6:0]  link_addr,
  output logic [15:0] link_wdata,
  input  logic        link_ack,
  input  logic        link_rsp_valid,
  input  logic [1:0]  link_rsp_codec,
  input  logic [6:0]  link_rsp_addr,
  input  logic [15:0] link_rsp_data
);
  cb_cmd_t     new_cmd;
  logic        legal, idle, accept, rsp_hit, timeout;
  logic [31:0] cmd_hold;

  assign new_cmd.codec = cmd_wdata[CB_IDX_W-1:0];
  assign new_cmd.rd    = cmd_wdata[CB_RD_BIT];
  assign new_cmd.addr  = cmd_wdata[CB_ADDR_LSB +: CB_ADDR_W];
  assign new_cmd.wdata = cmd_wdata[CB_DATA_LSB +: CB_DATA_W];

  assign legal  = (32'(new_cmd.codec) < NUM_CODECS) && !new_cmd.addr[0];
  assign accept = cmd_wr && idle && legal;

  always_ff @(posedge clk) begin
    if (rst)
      cmd_hold <= '0;
    else if (accept)
      cmd_hold <= cmd_wdata & ~(32'd1 << CB_BUSY_BIT);
  end

  cb_txn_ctrl #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_ctrl (
    .clk, .rst, .accept, .cmd(new_cmd), .frame_tick, .link_ack,
    .rsp_valid(link_rsp_valid), .rsp_codec(link_rsp_codec), .rsp_addr(link_rsp_addr),
    .idle, .rsp_hit, .timeout, .link_req, .link_codec, .link_rd, .link_addr, .link_wdata
  );

  cb_result_reg u_result (
    .clk, .rst, .clr_valid(accept && new_cmd.rd), .load(rsp_hit),
    .addr(link_rsp_addr), .data(link_rsp_data), .result(result_rdata)
  );

  cb_status_reg #(.NUM_CODECS(NUM_CODECS)) u_status (
    .clk, .rst, .nrdy_set(timeout), .nrdy_codec(link_codec), .frame_tick,
    .clr_wr(stat_clr_wr), .clr_mask(stat_clr_mask), .status(stat_rdata)
  );

  always_comb begin
    cmd_rdata              = cmd_hold;
    cmd_rdata[CB_BUSY_BIT] = link_req;
  end
endmodule

// File: rtl/cb_checker.sv
module cb_checker #(
  parameter int NUM_CODECS = 3
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] cmd_rdata,
  input logic [31:0] result_rdata,
  input logic [31:0] stat_rdata,
  input logic        frame_tick,
  input logic        link_req,
  input logic [1:0]  link_codec,
  input logic        link_rd,
  input logic [6:0]  link_addr,
  input logic        link_ack,
  input logic        link_rsp_valid
);
  a_r3_ack_releases_busy: assert property (@(posedge clk) disable iff (rst)
    (link_req && link_ack) |=> !cmd_rdata[8]);

  a_r4_request_held: assert property (@(posedge clk) disable iff (rst)
    (link_req && !link_ack && !frame_tick) |=>
      (link_req && $stable(link_addr) && $stable(link_codec) && $stable(link_rd)));

  a_r5_legal_request: assert property (@(posedge clk) disable iff (rst)
    link_req |-> ((32'(link_codec) < NUM_CODECS) && !link_addr[0]));

  a_r6_read_clears_valid: assert property (@(posedge clk) disable iff (rst)
    ($rose(link_req) && link_rd) |-> !result_rdata[8]);

  a_r7_valid_needs_response: assert property (@(posedge clk) disable iff (rst)
    $rose(result_rdata[8]) |-> $past(link_rsp_valid));

  a_r11_frame_flag: assert property (@(posedge clk) disable iff (rst)
    frame_tick |=> stat_rdata[13]);
endmodule

bind codec_reg_bridge cb_checker #(.NUM_CODECS(NUM_CODECS)) u_chk (
  .clk(clk), .rst(rst), .cmd_rdata(cmd_rdata), .result_rdata(result_rdata),
  .stat_rdata(stat_rdata), .frame_tick(frame_tick), .link_req(link_req),
  .link_codec(link_codec), .link_rd(link_rd), .link_addr(link_addr),
  .link_ack(link_ack), .link_rsp_valid(link_rsp_valid)
);

// File: tb/codec_reg_bridge_test.sv
module codec_reg_bridge_test;
  localparam int TMO = 4;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cmd_wr = 0, stat_clr_wr = 0, frame_tick = 0;
  logic        link_ack = 0, link_rsp_valid = 0;
  logic [31:0] cmd_wdata = '0, stat_clr_mask = '0;
  logic [1:0]  link_rsp_codec = '0;
  logic [6:0]  link_rsp_addr = '0;
  logic [15:0] link_rsp_data = '0;
  logic [31:0] cmd_rdata, result_rdata, stat_rdata;
  logic        link_req, link_rd;
  logic [1:0]  link_codec;
  logic [6:0]  link_addr;
  logic [15:0] link_wdata;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  logic [31:0] exp_res = '0;

  always #5 clk = ~clk;

  codec_reg_bridge #(.NUM_CODECS(3), .TIMEOUT_FRAMES(TMO)) uut (.*);

  // {present, codec[1:0], rd, addr[6:0], wdata[15:0]}
  localparam logic [26:0] VEC [8] = '{
    {1'b1, 2'd0, 1'b1, 7'h12, 16'h0000},
    {1'b1, 2'd1, 1'b0, 7'h20, 16'hBEEF},
    {1'b1, 2'd2, 1'b1, 7'h7E, 16'h0000},
    {1'b0, 2'd1, 1'b1, 7'h04, 16'h0000},
    {1'b1, 2'd0, 1'b0, 7'h00, 16'h1234},
    {1'b1, 2'd1, 1'b1, 7'h00, 16'h0000},
    {1'b0, 2'd2, 1'b0, 7'h10, 16'h5A5A},
    {1'b1, 2'd2, 1'b1, 7'h3C, 16'h0000}
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mdl(input logic [1:0] c, input logic [6:0] a);
    return {4'hC, 2'b00, c, 1'b0, a};
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] c, input logic rd,
                                     input logic [6:0] a, input logic [15:0] d);
    return {d, a, 1'b0, 5'b0, rd, c};
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0;
    end
  endtask

  task automatic ack();
    link_ack = 1'b1; @(negedge clk); link_ack = 1'b0;
  endtask

  task automatic respond(input logic [1:0] c, input logic [6:0] a, input logic [15:0] d);
    link_rsp_valid = 1'b1; link_rsp_codec = c; link_rsp_addr = a; link_rsp_data = d;
    @(negedge clk); link_rsp_valid = 1'b0;
  endtask

  task automatic clear_status(input logic [31:0] m);
    @(negedge clk); stat_clr_wr = 1'b1; stat_clr_mask = m;
    @(negedge clk); stat_clr_wr = 1'b0;
  endtask

  task automatic run_cmd(input logic pres, input logic [1:0] c, input logic rd,
                         input logic [6:0] a, input logic [15:0] d);
    issue(mk(c, rd, a, d));
    chk("R2 link_req", {31'b0, link_req}, 32'd1);
    chk("R2 link fields", {link_wdata, link_addr, link_rd, 6'b0, link_codec},
        {d, a, rd, 6'b0, c});
    chk("R3 busy set", cmd_rdata, mk(c, rd, a, d) | 32'h100);
    if (rd) begin
      exp_res[8] = 1'b0;
      chk("R6 valid cleared", result_rdata, exp_res);
    end
    if (pres) begin
      ack();
      chk("R3 busy clear", {cmd_rdata[8], link_req}, 32'd0);
      if (rd) begin
        respond(c, a, mdl(c, a));
        exp_res = {mdl(c, a), a, 1'b1, 8'h00};
        chk("R7 result", result_rdata, exp_res);
      end else begin
        chk("R9 write leaves result", result_rdata, exp_res);
      end
    end else begin
      tick(TMO - 1);
      chk("R10 still busy", {31'b0, cmd_rdata[8]}, 32'd1);
      tick(1);
      chk("R10 released", {cmd_rdata[8], link_req}, 32'd0);
      chk("R10 not-ready", {31'b0, stat_rdata[10 + c]}, 32'd1);
      chk("R10 result", result_rdata, exp_res);
      clear_status(32'hFFFF_FFFF);
      chk("R12 clear all", stat_rdata, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cmd", cmd_rdata, 32'd0);
    chk("R1 result", result_rdata, 32'd0);
    chk("R1 status", stat_rdata, 32'd0);
    chk("R1 req", {31'b0, link_req}, 32'd0);

    for (int i = 0; i < 8; i++)
      run_cmd(VEC[i][26], VEC[i][25:24], VEC[i][23], VEC[i][22:16], VEC[i][15:0]);

    // R5: illegal codec index and odd address
    issue(mk(2'd3, 1'b1, 7'h02, 16'h0));
    chk("R5 codec3 no req", {31'b0, link_req}, 32'd0);
    chk("R5 codec3 cmd kept", cmd_rdata, mk(2'd2, 1'b1, 7'h3C, 16'h0));
    issue(mk(2'd0, 1'b0, 7'h05, 16'h1111));
    chk("R5 odd addr no req", {31'b0, link_req}, 32'd0);
    chk("R5 odd addr cmd kept", cmd_rdata, mk(2'd2, 1'b1, 7'h3C, 16'h0));

    // R4 / R8: commands while busy or waiting, stale responses
    issue(mk(2'd0, 1'b1, 7'h08, 16'h0));
    exp_res[8] = 1'b0;
    issue(mk(2'd1, 1'b0, 7'h0A, 16'h7777));
    chk("R4 busy ignore link", {link_addr, link_codec}, {7'h08, 2'd0});
    chk("R4 busy ignore cmd", cmd_rdata, mk(2'd0, 1'b1, 7'h08, 16'h0) | 32'h100);
    ack();
    issue(mk(2'd1, 1'b0, 7'h0A, 16'h7777));
    chk("R4 wait ignore req", {31'b0, link_req}, 32'd0);
    chk("R4 wait ignore cmd", cmd_rdata, mk(2'd0, 1'b1, 7'h08, 16'h0));
    respond(2'd0, 7'h0A, 16'h9999);
    chk("R8 wrong addr", result_rdata, exp_res);
    respond(2'd1, 7'h08, 16'h9999);
    chk("R8 wrong codec", result_rdata, exp_res);
    respond(2'd0, 7'h08, 16'h4321);
    exp_res = {16'h4321, 7'h08, 1'b1, 8'h00};
    chk("R7 after stale", result_rdata, exp_res);
    respond(2'd0, 7'h08, 16'hDEAD);
    chk("R8 no read waiting", result_rdata, exp_res);

    // R10: acknowledged read with no response
    issue(mk(2'd1, 1'b1, 7'h02, 16'h0));
    exp_res[8] = 1'b0;
    ack();
    tick(TMO - 1);
    chk("R10 wait pending", {31'b0, stat_rdata[11]}, 32'd0);
    tick(1);
    chk("R10 wait not-ready", {31'b0, stat_rdata[11]}, 32'd1);
    chk("R10 wait result", result_rdata, exp_res);
    respond(2'd1, 7'h02, 16'hAAAA);
    chk("R8 late response", result_rdata, exp_res);
    issue(mk(2'd2, 1'b0, 7'h06, 16'h0F0F));
    chk("R10 next accepted", {31'b0, link_req}, 32'd1);
    ack();

    // R11 / R12: frame flag and clear priority
    clear_status(32'hFFFF_FFFF);
    chk("R12 cleared", stat_rdata, 32'd0);
    tick(1);
    chk("R11 frame flag", stat_rdata, 32'h2000);
    @(negedge clk); frame_tick = 1'b1; stat_clr_wr = 1'b1; stat_clr_mask = 32'h2000;
    @(negedge clk); frame_tick = 1'b0; stat_clr_wr = 1'b0;
    chk("R12 set wins", stat_rdata, 32'h2000);
    clear_status(32'h0000_0400);
    chk("R12 unmasked kept", stat_rdata, 32'h2000);
    clear_status(32'h0000_2000);
    chk("R12 masked cleared", stat_rdata, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule